// File: doc/BRIEF.md
# Carry-Skip Adder

This block adds two unsigned operands and an incoming carry. It produces a sum of the operand width and a carry-out. The word is cut into equal slices. Inside each slice the carry passes bit by bit through full-adder cells. At the top of each slice a two-way selector chooses the outgoing carry. When every bit in the slice propagates, the selector passes the slice's incoming carry straight through. Otherwise it takes the carry that rippled up inside the slice. A non-propagating slice either kills or generates its carry, so that rippled carry does not depend on the slice's own carry-in. The skip path therefore only has to carry a value across slices that propagate.

Two parameters set the word width and the slice width. The word width must be a whole multiple of the slice width, and elaboration stops if it is not. The defaults are 16 and 4, which gives four slices. A third parameter, on by default, places a register on the sum and carry-out, so results appear one clock after the operands. The register clears asynchronously on an active-low reset. With the parameter off, the block is purely combinational.

Top module: `csk_adder`

## Requirements
- R1: With the output register enabled, `{cout, sum}` one clock after a set of operands equals `op_a + op_b + cin` computed to WIDTH+1 bits.
- R2: While `rst_n` is low, `sum` reads all zeros and `cout` reads 0.
- R3: A slice in which every bit has exactly one operand bit set passes its incoming carry unchanged to the next slice. For example, 0xFFFF + 0x0000 with cin=1 gives sum 0x0000 and cout 1, and with cin=0 gives sum 0xFFFF and cout 0.
- R4: A slice whose most significant bit has both operand bits set sends a carry of 1 to the next slice, whatever carry it received. For example, 0x8000 + 0x8000 gives sum 0x0000 and cout 1.
- R5: A slice that does not fully propagate sends on its internally rippled carry. A bit with both operand bits clear absorbs any carry below it. For example, 0x0000 + 0x0000 with cin=1 gives 0x0001 and cout 0.
- R6: `cout` is the outgoing carry of the most significant slice, including a carry generated in a low slice that skips across all higher slices. For example, 0xFFF8 + 0x0008 gives sum 0x0000 and cout 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Sum bits |
| cout | output | 1 | Carry out of the top bit |

## Verification
In a single cycle, a carry can be generated in a low slice and then carried by the skip selectors of every slice above it. Both functions then act on the same add. This case is provoked with operands such as 0xFFF8 + 0x0008: slice 0 generates a carry and the three upper slices all propagate. It is judged by requiring an all-zero sum and a carry-out of 1. The checker also compares, in every slice and every cycle, the rippled carry against the skipped carry whenever the slice propagates. The bench applies targeted and random operand pairs every clock and compares each registered result against a queue of behaviourally computed sums.

// File: rtl/csk_pkg.sv
package csk_pkg;
  // One-bit full add; returns {carry_out, sum}.
  function automatic logic [1:0] fa_bit(input logic a, input logic b, input logic c);
    logic g, p;
    g = a & b;
    p = a ^ b;
    return {g | (p & c), p ^ c};
  endfunction

  // True when every bit of a slice propagates.
  function automatic logic slice_prop(input logic [31:0] a, input logic [31:0] b, input int w);
    logic r;
    r = 1'b1;
    for (int i = 0; i < w; i++) r = r & (a[i] ^ b[i]);
    return r;
  endfunction
endpackage

// File: rtl/csk_slice.sv
module csk_slice #(
  parameter int BLK = 4
) (
  input  logic [BLK-1:0] a,
  input  logic [BLK-1:0] b,
  input  logic           cin,
  output logic [BLK-1:0] s,
  output logic           cout,
  output logic           prop_all,
  output logic           rip_cout
);
  import csk_pkg::*;

  logic [BLK:0] c;
  assign c[0] = cin;

  genvar i;
  generate
    for (i = 0; i < BLK; i++) begin : g_bit
      logic [1:0] r;
      assign r        = fa_bit(a[i], b[i], c[i]);
      assign s[i]     = r[0];
      assign c[i+1]   = r[1];
    end
  endgenerate

  assign prop_all = &(a ^ b);
  assign rip_cout = c[BLK];
  // Skip selector: a fully propagating slice forwards its carry-in.
  assign cout     = prop_all ? cin : rip_cout;
endmodule

// File: rtl/csk_adder.sv
module csk_adder #(
  parameter int WIDTH   = 16,
  parameter int BLK     = 4,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  localparam int NBLK = WIDTH / BLK;

  generate
    if (WIDTH % BLK != 0) begin : g_bad_split
      $error("csk_adder: WIDTH must be a multiple of BLK");
    end
  endgenerate

  logic [NBLK:0]    chain;
  logic [NBLK-1:0]  blk_prop;
  logic [NBLK-1:0]  blk_cin;
  logic [NBLK-1:0]  blk_cout;
  logic [NBLK-1:0]  blk_rip;
  logic [WIDTH-1:0] sum_c;

  assign chain[0] = cin;

  genvar k;
  generate
    for (k = 0; k < NBLK; k++) begin : g_slice
      csk_slice #(.BLK(BLK)) u_slice (
        .a        (op_a[k*BLK +: BLK]),
        .b        (op_b[k*BLK +: BLK]),
        .cin      (chain[k]),
        .s        (sum_c[k*BLK +: BLK]),
        .cout     (chain[k+1]),
        .prop_all (blk_prop[k]),
        .rip_cout (blk_rip[k])
      );
      assign blk_cin[k]  = chain[k];
      assign blk_cout[k] = chain[k+1];
    end
  endgenerate

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sum  <= '0;
          cout <= 1'b0;
        end else begin
          sum  <= sum_c;
          cout <= chain[NBLK];
        end
      end
    end else begin : g_comb
      assign sum  = sum_c;
      assign cout = chain[NBLK];
    end
  endgenerate
endmodule

// File: rtl/csk_adder_chk.sv
module csk_adder_chk #(
  parameter int WIDTH   = 16,
  parameter int BLK     = 4,
  parameter bit REG_OUT = 1'b1,
  localparam int NBLK   = WIDTH / BLK
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic             cin,
  input logic [WIDTH-1:0] sum,
  input logic             cout,
  input logic [NBLK-1:0]  blk_prop,
  input logic [NBLK-1:0]  blk_cin,
  input logic [NBLK-1:0]  blk_cout,
  input logic [NBLK-1:0]  blk_rip
);
  genvar k;
  generate
    for (k = 0; k < NBLK; k++) begin : g_blk
      // R3: when a slice propagates, its ripple chain agrees with the skip path
      p_skip_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
        blk_prop[k] |-> (blk_rip[k] == blk_cin[k]));
      // R4: a generate at the slice's top bit forces a carry out
      p_top_gen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_a[k*BLK+BLK-1] && op_b[k*BLK+BLK-1]) |-> blk_cout[k]);
      // R5: a non-propagating slice sends on its rippled carry
      p_ripple_pick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !blk_prop[k] |-> (blk_cout[k] == blk_rip[k]));
    end
  endgenerate

  generate
    if (REG_OUT) begin : g_reg_chk
      // R1: registered result equals the arithmetic sum of the previous operands
      p_sum_r1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ({cout, sum} == ({1'b0, $past(op_a)} + {1'b0, $past(op_b)} + (WIDTH+1)'($past(cin)))));
      // R6: carry-out follows the top slice's carry
      p_cout_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cout == $past(blk_cout[NBLK-1])));
    end else begin : g_comb_chk
      p_sum_r1: assert property (@(posedge clk) disable iff (!rst_n)
        {cout, sum} == ({1'b0, op_a} + {1'b0, op_b} + (WIDTH+1)'(cin)));
      p_cout_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cout == blk_cout[NBLK-1]);
    end
  endgenerate
endmodule

bind csk_adder csk_adder_chk #(.WIDTH(WIDTH), .BLK(BLK), .REG_OUT(REG_OUT)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .op_a     (op_a),
  .op_b     (op_b),
  .cin      (cin),
  .sum      (sum),
  .cout     (cout),
  .blk_prop (blk_prop),
  .blk_cin  (blk_cin),
  .blk_cout (blk_cout),
  .blk_rip  (blk_rip)
);

// File: tb/sim_csk_adder.sv
module sim_csk_adder;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;
  logic         cin = 1'b0;
  logic [W-1:0] sum;
  logic         cout;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [W:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  csk_adder #(.WIDTH(W), .BLK(4), .REG_OUT(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .cin(cin),
    .sum(sum), .cout(cout)
  );

  task automatic check(input string tag, input logic [W:0] got, input logic [W:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h expected=%h", tag, got, exp);
    end
  endtask

  // At each falling edge: judge the result of the previous step, then drive a new one.
  task automatic step(input logic [W-1:0] a, input logic [W-1:0] b, input logic c, input string tag);
    logic [W:0] e;
    @(negedge clk);
    if (exp_q.size() > 0) check(tag_q.pop_front(), {cout, sum}, exp_q.pop_front());
    op_a = a; op_b = b; cin = c;
    e = W'(a);
    e = e + {1'b0, b} + (W+1)'(c);
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R2 reset", {cout, sum}, '0);
    op_a = 16'hFFFF; op_b = 16'hFFFF; cin = 1'b1;
    @(negedge clk);
    check("R2 reset with inputs", {cout, sum}, '0);
    rst_n = 1'b1;

    step(16'hFFFF, 16'h0000, 1'b1, "R3 all propagate cin1");
    step(16'hFFFF, 16'h0000, 1'b0, "R3 all propagate cin0");
    step(16'h0F0F, 16'hF0F0, 1'b1, "R3 mixed propagate");
    step(16'h8000, 16'h8000, 1'b0, "R4 top generate");
    step(16'h0008, 16'h0008, 1'b0, "R4 slice0 generate");
    step(16'h000F, 16'h000F, 1'b1, "R4 generate with cin");
    step(16'h0000, 16'h0000, 1'b1, "R5 kill absorbs cin");
    step(16'hAAAA, 16'hAAAA, 1'b0, "R5 alternating");
    step(16'h5555, 16'h5555, 1'b1, "R5 alternating cin");
    step(16'hFFF8, 16'h0008, 1'b0, "R6 generate then skip");
    step(16'h7FFF, 16'h0001, 1'b0, "R6 no carry out");
    step(16'hFFFF, 16'hFFFF, 1'b1, "R6 all ones");
    for (int i = 0; i < 2000; i++)
      step(W'($urandom), W'($urandom), 1'($urandom), "R1 random");
    for (int i = 0; i < 16; i++)
      step(16'hFFFF >> i, 16'h0001 << (i % 4), 1'b0, "R1 sweep");
    step(16'h0000, 16'h0000, 1'b0, "R1 drain");
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (10000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule